// File: doc/BRIEF.md
# Segment Buffer Invalidate-All Engine

This block keeps a small table of segment lookaside entries. Each entry holds an effective segment identifier (ESID) and a valid bit. It also carries out the invalidate-all operation on that table. A one-cycle start pulse begins a walk. The walk visits one entry per clock, from index 0 up to the last index. Each visited entry that is valid has its valid bit cleared, and its ESID is kept. Entries that are already invalid are left alone.

Every accepted start also raises a request to flush the local translation cache, whether or not any entry was valid. The request is needed because overwriting an entry through the write port never flushes stale lookaside data, so the table's valid bits cannot show what the cache still holds. The request stays high until a flush acknowledge arrives.

Software or the surrounding pipeline loads entries through a simple write port. While a walk runs, a write is stalled: the stall flag is raised and the requester holds its write until busy drops.

The controller has three states:
- IDLE: waiting for start.
- WALK: visiting one index per cycle, with busy high.
- FINISH: a single cycle with done high and busy low.

It has four transitions:
- launch: IDLE or FINISH to WALK, on start.
- step: WALK to WALK, at any index below the last.
- wrap: WALK to FINISH, at the last index.
- settle: FINISH to IDLE, when no start is present.

Top module: `sbia_engine`

## Requirements
- R1: A start pulse sampled while busy is low makes busy high from the next cycle. Busy then stays high for exactly NUM_ENTRIES cycles while indices 0 to NUM_ENTRIES-1 are visited in turn.
- R2: In the cycle after the last index is visited, done is high for exactly one cycle and busy is low in that same cycle.
- R3: After a walk, every entry that was valid reads back with valid 0 and an unchanged ESID.
- R4: After a walk, every entry that was invalid reads back with valid 0 and an unchanged ESID.
- R5: Every accepted start raises flush_req_o in the following cycle, even when no entry was valid.
- R6: flush_req_o stays high until flush_ack_i is sampled high. After that it is low from the next cycle, unless a new start is accepted in the same cycle.
- R7: A write through the write port never raises flush_req_o, including a write over a valid entry.
- R8: A start pulse sampled while busy is high is ignored: the walk length is unchanged and no second walk follows.
- R9: While busy is high, a write request raises wr_stall_o and leaves the table unchanged. A write request held until busy drops is stored in the first cycle with busy low.
- R10: While busy is low, wr_en_i stores wr_esid_i and wr_valid_i at wr_idx_i. The combinational read port (rd_idx_i to rd_esid_o and rd_valid_o) shows the new value from the next cycle.
- R11: After reset, busy, done and flush_req_o are low, and every entry reads back with valid 0 and ESID 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Invalidate-all start pulse |
| flush_ack_i | input | 1 | Acknowledges the flush request |
| wr_en_i | input | 1 | Write request |
| wr_idx_i | input | IDX_W | Entry index to write |
| wr_esid_i | input | ESID_W | ESID to store |
| wr_valid_i | input | 1 | Valid bit to store |
| rd_idx_i | input | IDX_W | Entry index to read |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle end-of-walk pulse |
| flush_req_o | output | 1 | Local translation-cache flush request, held until acknowledged |
| wr_stall_o | output | 1 | Write request is being held off by a walk |
| rd_esid_o | output | ESID_W | ESID at rd_idx_i |
| rd_valid_o | output | 1 | Valid bit at rd_idx_i |

## Verification
The walk is tried with several valid-bit masks before each start:
- All clear, which shows that the flush request does not depend on the table contents.
- All set.
- Alternating patterns, which separate clearing a valid entry from leaving an invalid one alone.
- A single set bit at the first index and a single set bit at the last index, which expose an off-by-one at either end of the walk.

Each ESID is distinct, so keeping the ESID can be told apart from writing a wrong value back. Directed cases cover the following:
- A start injected during a walk, which separates ignoring it from restarting.
- A write held across a walk, which separates stalling from dropping or applying it early.
- A write over a valid entry, which shows that writes never flush.
- A flush request left unacknowledged for several cycles.

// File: rtl/sbia_pkg.sv
package sbia_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WALK   = 2'd1,
        ST_FINISH = 2'd2
    } walk_state_t;

endpackage

// File: rtl/sbia_walker.sv
module sbia_walker
    import sbia_pkg::*;
#(
    parameter int NUM_ENTRIES = 8,
    localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             launch_o,
    output logic             visit_o,
    output logic [IDX_W-1:0] idx_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENTRIES - 1);

    walk_state_t      state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_IDLE, ST_FINISH: begin
                if (start_i) begin            // launch
                    state_d = ST_WALK;
                    idx_d   = '0;
                end else begin                // settle
                    state_d = ST_IDLE;
                end
            end
            ST_WALK: begin
                if (idx_q == LAST_IDX) begin  // wrap
                    state_d = ST_FINISH;
                    idx_d   = '0;
                end else begin                // step
                    idx_d = idx_q + 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy_o   = 1'b0;
        done_o   = 1'b0;
        visit_o  = 1'b0;
        launch_o = 1'b0;
        unique case (state_q)
            ST_IDLE: launch_o = start_i;
            ST_WALK: begin
                busy_o  = 1'b1;
                visit_o = 1'b1;
            end
            ST_FINISH: begin
                done_o   = 1'b1;
                launch_o = start_i;
            end
            default: ;
        endcase
    end

    assign idx_o = idx_q;

    p_one_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (visit_o && idx_o != LAST_IDX) |=> (visit_o && idx_o == $past(idx_o) + 1'b1));

    p_done_after_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (visit_o && idx_o == LAST_IDX) |=> (done_o && !busy_o));

    p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_busy_done_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({busy_o, done_o}));

    p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !launch_o);

endmodule

// File: rtl/sbia_array.sv
module sbia_array #(
    parameter int NUM_ENTRIES = 8,
    parameter int ESID_W      = 16,
    localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [ESID_W-1:0] wr_esid_i,
    input  logic              wr_valid_i,
    input  logic              visit_i,
    input  logic [IDX_W-1:0]  visit_idx_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output logic [ESID_W-1:0] rd_esid_o,
    output logic              rd_valid_o
);
    logic [ESID_W-1:0] esid_q  [NUM_ENTRIES];
    logic              valid_q [NUM_ENTRIES];

    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_entry
        logic hit_wr, hit_clr;
        assign hit_wr  = wr_en_i && (wr_idx_i == IDX_W'(e));
        assign hit_clr = visit_i && (visit_idx_i == IDX_W'(e)) && valid_q[e];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                esid_q[e]  <= '0;
                valid_q[e] <= 1'b0;
            end else if (hit_wr) begin
                esid_q[e]  <= wr_esid_i;
                valid_q[e] <= wr_valid_i;
            end else if (hit_clr) begin
                valid_q[e] <= 1'b0;
            end
        end
    end

    assign rd_esid_o  = esid_q[rd_idx_i];
    assign rd_valid_o = valid_q[rd_idx_i];

    p_no_write_in_walk_r9: assert property (@(posedge clk) disable iff (!rst_n)
        visit_i |-> !wr_en_i);

    p_clear_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        visit_i |=> !valid_q[$past(visit_idx_i)]);

    p_keep_esid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        visit_i |=> (esid_q[$past(visit_idx_i)] == $past(esid_q[visit_idx_i])));

endmodule

// File: rtl/sbia_flush.sv
module sbia_flush (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic ack_i,
    output logic req_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      req_o <= 1'b0;
        else if (set_i)  req_o <= 1'b1;
        else if (ack_i)  req_o <= 1'b0;
    end

    p_raise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> req_o);

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !ack_i) |=> req_o);

    p_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && ack_i && !set_i) |=> !req_o);

endmodule

// File: rtl/sbia_engine.sv
module sbia_engine #(
    parameter int NUM_ENTRIES = 8,
    parameter int ESID_W      = 16,
    localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              flush_ack_i,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [ESID_W-1:0] wr_esid_i,
    input  logic              wr_valid_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              flush_req_o,
    output logic              wr_stall_o,
    output logic [ESID_W-1:0] rd_esid_o,
    output logic              rd_valid_o
);
    logic             launch, visit, wr_go;
    logic [IDX_W-1:0] visit_idx;

    sbia_walker #(.NUM_ENTRIES(NUM_ENTRIES)) u_walker (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .busy_o   (busy_o),
        .done_o   (done_o),
        .launch_o (launch),
        .visit_o  (visit),
        .idx_o    (visit_idx)
    );

    assign wr_go      = wr_en_i && !busy_o;
    assign wr_stall_o = wr_en_i && busy_o;

    sbia_array #(.NUM_ENTRIES(NUM_ENTRIES), .ESID_W(ESID_W)) u_array (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (wr_go),
        .wr_idx_i    (wr_idx_i),
        .wr_esid_i   (wr_esid_i),
        .wr_valid_i  (wr_valid_i),
        .visit_i     (visit),
        .visit_idx_i (visit_idx),
        .rd_idx_i    (rd_idx_i),
        .rd_esid_o   (rd_esid_o),
        .rd_valid_o  (rd_valid_o)
    );

    sbia_flush u_flush (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (launch),
        .ack_i (flush_ack_i),
        .req_o (flush_req_o)
    );

    p_flush_only_on_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flush_req_o) |-> $past(launch));

    p_launch_makes_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> busy_o);

endmodule

// File: tb/sbia_engine_test.sv
module sbia_engine_test;
    localparam int N  = 8;
    localparam int EW = 16;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0, flush_ack_i = 1'b0;
    logic          wr_en_i = 1'b0, wr_valid_i = 1'b0;
    logic [IW-1:0] wr_idx_i = '0, rd_idx_i = '0;
    logic [EW-1:0] wr_esid_i = '0;
    logic          busy_o, done_o, flush_req_o, wr_stall_o, rd_valid_o;
    logic [EW-1:0] rd_esid_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    sbia_engine #(.NUM_ENTRIES(N), .ESID_W(EW)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .flush_ack_i(flush_ack_i),
        .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i), .wr_esid_i(wr_esid_i),
        .wr_valid_i(wr_valid_i), .rd_idx_i(rd_idx_i), .busy_o(busy_o),
        .done_o(done_o), .flush_req_o(flush_req_o), .wr_stall_o(wr_stall_o),
        .rd_esid_o(rd_esid_o), .rd_valid_o(rd_valid_o)
    );

    localparam logic [N-1:0] MASKS [6] = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h01, 8'h80};

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [EW-1:0] esid_of(input int v, input int i);
        return EW'(v * 256 + i * 17 + 3);
    endfunction

    task automatic put(input int idx, input logic [EW-1:0] esid, input logic v);
        wr_en_i = 1'b1; wr_idx_i = IW'(idx); wr_esid_i = esid; wr_valid_i = v;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic peek(input int idx, output logic [EW-1:0] e, output logic v);
        rd_idx_i = IW'(idx);
        #1;
        e = rd_esid_o; v = rd_valid_o;
    endtask

    // start, then count busy cycles; a start is re-driven at busy cycle "inject"
    task automatic walk(input int inject, output int cnt);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        cnt = 0;
        while (busy_o && cnt < 64) begin
            cnt++;
            start_i = (cnt == inject);
            @(negedge clk);
        end
        start_i = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [EW-1:0] e;
        logic          v;
        int            cnt;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        chk(!busy_o && !done_o && !flush_req_o, "R11 outputs", {busy_o, done_o, flush_req_o}, 0);
        for (int i = 0; i < N; i++) begin
            peek(i, e, v);
            chk(e == 0 && v == 0, "R11 entry", {e, v}, 0);
        end

        // table-driven walks
        for (int t = 0; t < 6; t++) begin
            for (int i = 0; i < N; i++) put(i, esid_of(t, i), MASKS[t][i]);
            for (int i = 0; i < N; i++) begin
                peek(i, e, v);
                chk(e == esid_of(t, i) && v == MASKS[t][i], "R10 write",
                    {e, v}, {esid_of(t, i), MASKS[t][i]});
            end
            chk(!flush_req_o, "R7 no flush after writes", flush_req_o, 0);
            walk(-1, cnt);
            chk(cnt == N, "R1 busy length", cnt, N);
            chk(done_o && !busy_o, "R2 done with busy low", {done_o, busy_o}, 2'b10);
            chk(flush_req_o, "R5 flush raised", flush_req_o, 1);
            for (int i = 0; i < N; i++) begin
                peek(i, e, v);
                if (MASKS[t][i])
                    chk(e == esid_of(t, i) && v == 0, "R3 valid entry cleared",
                        {e, v}, {esid_of(t, i), 1'b0});
                else
                    chk(e == esid_of(t, i) && v == 0, "R4 invalid entry untouched",
                        {e, v}, {esid_of(t, i), 1'b0});
            end
            @(negedge clk);
            chk(!done_o && !busy_o, "R2 done one cycle", {done_o, busy_o}, 0);
            chk(flush_req_o, "R6 flush held", flush_req_o, 1);
            flush_ack_i = 1'b1;
            @(negedge clk);
            flush_ack_i = 1'b0;
            chk(!flush_req_o, "R6 flush dropped after ack", flush_req_o, 0);
        end

        // R8: start during a walk is ignored
        walk(3, cnt);
        chk(cnt == N, "R8 walk length with extra start", cnt, N);
        chk(done_o, "R8 done", done_o, 1);
        @(negedge clk);
        chk(!busy_o, "R8 no second walk", busy_o, 0);
        repeat (3) @(negedge clk);
        chk(flush_req_o, "R6 flush held without ack", flush_req_o, 1);
        flush_ack_i = 1'b1;
        @(negedge clk);
        flush_ack_i = 1'b0;

        // R9: write held across a walk
        put(2, 16'hAAAA, 1'b0);
        rd_idx_i = 3'd2;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wr_en_i = 1'b1; wr_idx_i = 3'd2; wr_esid_i = 16'hBEEF; wr_valid_i = 1'b1;
        cnt = 0;
        while (busy_o && cnt < 64) begin
            #1;
            chk(wr_stall_o, "R9 stall raised", wr_stall_o, 1);
            chk(rd_esid_o == 16'hAAAA && !rd_valid_o, "R9 table unchanged", rd_esid_o, 16'hAAAA);
            cnt++;
            @(negedge clk);
        end
        chk(!wr_stall_o, "R9 stall released", wr_stall_o, 0);
        @(negedge clk);
        wr_en_i = 1'b0;
        #1;
        chk(rd_esid_o == 16'hBEEF && rd_valid_o, "R9 held write applied",
            {rd_esid_o, rd_valid_o}, {16'hBEEF, 1'b1});
        flush_ack_i = 1'b1;
        @(negedge clk);
        flush_ack_i = 1'b0;

        // R7: overwrite a valid entry, no flush
        put(2, 16'h1234, 1'b1);
        repeat (2) @(negedge clk);
        chk(!flush_req_o, "R7 overwrite no flush", flush_req_o, 0);
        peek(2, e, v);
        chk(e == 16'h1234 && v, "R10 overwrite stored", {e, v}, {16'h1234, 1'b1});

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule